// File: doc/BRIEF.md
# Sequential Linear-Kernel Two-Class Classifier in Logarithmic Arithmetic

This block sorts an unknown instance into one of two classes with a linear-kernel support vector machine. Training happens off-chip and leaves one weight per attribute and a bias value. The weights sit in a parameter-defined weight store, so no support vectors or coefficients are held. Every value is a 10-bit logarithmic word: bit 9 is the sign (1 = negative) and bits 8:0 hold a two's complement base-2 logarithm of the magnitude, counted in sixteenths. Zero has no encoding, and the smallest magnitude is 2^-16.

A start pulse copies the whole instance into an internal buffer, presets the accumulator to the bias and clears the attribute counter. On each of the next `N_ATTR` cycles one attribute is multiplied by its weight. The multiply adds the two logs and XORs the two signs. The product is then summed into the accumulator by a logarithmic adder that uses a shift-based approximation for both the sum and the difference correction. When the final attribute has been accumulated, the block raises a one-cycle done strobe and shows the class taken from the accumulator sign. Between instances the block holds its state, so the host may either feed instances at a fixed rate or stop the clock.

Top module: `lns_svm_classifier`

## Requirements
- R1: A product has sign = attribute sign XOR weight sign and log = attribute log + weight log, saturated to the range -256..255.
- R2: Adding two words of equal sign: let L be the larger log, dlt the difference of logs, q = dlt/16, r = dlt mod 16, n = q + (r != 0), f = 0 if r = 0 else 16 - r, and T = ((16 + f) * 256) >> n, or 0 when n > 12. The result keeps the common sign and has log L + (T >> 8), saturated at 255.
- R3: Adding two words of opposite sign with unequal logs, with T as in R2: if T = 0 the result is the larger-log operand. Otherwise D = 4096 - T, p is the index of the highest set bit of D, and the log is L + 16*(p - 12) + bits 10:7 of (D << (11 - p)), saturated at -256. The sign is that of the larger-log operand.
- R4: Two opposite-sign words with equal logs sum to sign 0 and log -256, the smallest positive magnitude, which reads as the positive class.
- R5: A start seen while idle captures the instance, sets the accumulator to the bias and clears the attribute counter.
- R6: One product per cycle is accumulated, in attribute order 0 to N_ATTR-1. Done is high in the cycle after the N_ATTR-th rising edge that follows the edge which sampled start.
- R7: Done lasts exactly one cycle, and class is 1 when the accumulator sign bit is 0 and 0 otherwise.
- R8: A start pulse while a classification is running is ignored: neither the buffered instance nor the result changes.
- R9: While idle the accumulator holds, so the class output stays stable and done stays low until the next start.
- R10: Reset leaves the block idle with done low and the accumulator at +1.0, so class reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a classification (ignored while busy) |
| inst_i | input | N_ATTR*10 | Unknown instance, attribute k in bits 10k+9:10k |
| done_o | output | 1 | One-cycle strobe: class is valid |
| class_o | output | 1 | 1 = positive class, 0 = negative class |

## Verification
The assertions assume that rst_n is released synchronously and that start_i and inst_i are stable around the rising edge. Under those conditions, any start that arrives while a run is in progress must leave the buffer untouched. The bench changes its inputs only on falling edges and sends starts at every phase: while idle, in the strobe cycle, and in the middle of a run. It covers exact cancellation, log saturation in both directions, and pseudo-random instances across the full word range, so both adder branches, the T = 0 case and the cancellation path all appear under the same timing.

// File: rtl/svm_lns_pkg.sv
`timescale 1ns/1ps
package svm_lns_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ctl_state_e;
  localparam int GUARD_BITS = 8;
endpackage

// File: rtl/svm_lns_mul.sv
`timescale 1ns/1ps
module svm_lns_mul #(
  parameter int LOGW = 9
) (
  input  logic [LOGW:0] a_i,
  input  logic [LOGW:0] b_i,
  output logic [LOGW:0] p_o
);
  localparam int LMIN = -(1 << (LOGW - 1));
  localparam int LMAX = (1 << (LOGW - 1)) - 1;

  always_comb begin
    int sum;
    sum = int'($signed(a_i[LOGW-1:0])) + int'($signed(b_i[LOGW-1:0]));
    if (sum > LMAX) sum = LMAX;
    if (sum < LMIN) sum = LMIN;
    p_o = {a_i[LOGW] ^ b_i[LOGW], sum[LOGW-1:0]};
  end
endmodule

// File: rtl/svm_lns_add.sv
`timescale 1ns/1ps
module svm_lns_add #(
  parameter int LOGW = 9,
  parameter int FRAC = 4
) (
  input  logic [LOGW:0] a_i,
  input  logic [LOGW:0] b_i,
  output logic [LOGW:0] y_o
);
  import svm_lns_pkg::*;
  localparam int G    = GUARD_BITS;
  localparam int Q    = FRAC + G;
  localparam int ONE  = 1 << FRAC;
  localparam int LMIN = -(1 << (LOGW - 1));
  localparam int LMAX = (1 << (LOGW - 1)) - 1;

  always_comb begin
    int la, lb, lbig, dlt, q, rm, n, f, t, dd, p, res;
    logic sbig, sg, cancel;
    la = int'($signed(a_i[LOGW-1:0]));
    lb = int'($signed(b_i[LOGW-1:0]));
    if (la >= lb) begin
      lbig = la; dlt = la - lb; sbig = a_i[LOGW];
    end else begin
      lbig = lb; dlt = lb - la; sbig = b_i[LOGW];
    end
    q  = dlt >> FRAC;
    rm = dlt & (ONE - 1);
    n  = q + ((rm != 0) ? 1 : 0);
    f  = (rm == 0) ? 0 : ONE - rm;
    t  = (n > Q) ? 0 : (((ONE + f) << G) >> n);
    cancel = 1'b0;
    dd = 0;
    p  = 0;
    if (a_i[LOGW] == b_i[LOGW]) begin
      sg  = a_i[LOGW];
      res = lbig + (t >> G);
    end else begin
      sg = sbig;
      dd = (1 << Q) - t;
      if (t == 0) begin
        res = lbig;
      end else if (dd == 0) begin
        res = LMIN;
        cancel = 1'b1;
      end else begin
        for (int k = 0; k < Q; k++) begin
          if (((dd >> k) & 1) != 0) p = k;
        end
        res = lbig + ONE * (p - Q) + (((dd << (Q - 1 - p)) >> (Q - 1 - FRAC)) & (ONE - 1));
      end
    end
    if (res > LMAX) res = LMAX;
    if (res < LMIN) res = LMIN;
    y_o = cancel ? {1'b0, res[LOGW-1:0]} : {sg, res[LOGW-1:0]};
  end
endmodule

// File: rtl/svm_seq_ctrl.sv
`timescale 1ns/1ps
module svm_seq_ctrl #(
  parameter int N_ATTR = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start_i,
  output logic                                 load_o,
  output logic                                 step_o,
  output logic                                 busy_o,
  output logic [((N_ATTR > 1) ? $clog2(N_ATTR) : 1)-1:0] idx_o,
  output logic                                 done_o
);
  import svm_lns_pkg::*;
  localparam int CW = (N_ATTR > 1) ? $clog2(N_ATTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_ATTR - 1);

  ctl_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        cnt_d   = '0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = load_o | step_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign idx_o  = cnt_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q <= LAST)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1)); // R6
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q == LAST) |=> (done_q && state_q == ST_IDLE)); // R6
endmodule

// File: rtl/lns_svm_classifier.sv
`timescale 1ns/1ps
module lns_svm_classifier #(
  parameter int N_ATTR = 4,
  parameter int LOGW   = 9,
  parameter int FRAC   = 4,
  parameter logic [N_ATTR*(LOGW+1)-1:0] WEIGHTS = {10'h1F0, 10'h008, 10'h210, 10'h000},
  parameter logic [LOGW:0] BIAS = 10'h3E0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [N_ATTR*(LOGW+1)-1:0]   inst_i,
  output logic                         done_o,
  output logic                         class_o
);
  localparam int W  = LOGW + 1;
  localparam int CW = (N_ATTR > 1) ? $clog2(N_ATTR) : 1;
  localparam logic [LOGW-1:0] LMIN_BITS = {1'b1, {(LOGW-1){1'b0}}};

  logic          load, step, busy;
  logic [CW-1:0] idx;
  logic [N_ATTR*W-1:0] inst_q;
  logic [W-1:0]  attr [N_ATTR];
  logic [W-1:0]  wrom [N_ATTR];
  logic [W-1:0]  attr_sel, w_sel, prod, acc_sum, acc_q;

  svm_seq_ctrl #(.N_ATTR(N_ATTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .busy_o(busy), .idx_o(idx), .done_o(done_o)
  );

  for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    inst_q[k*W +: W] <= '0;
      else if (load) inst_q[k*W +: W] <= inst_i[k*W +: W];
    end
    assign attr[k] = inst_q[k*W +: W];
    assign wrom[k] = WEIGHTS[k*W +: W];
  end

  always_comb begin
    attr_sel = attr[0];
    w_sel    = wrom[0];
    for (int k = 0; k < N_ATTR; k++) begin
      if (idx == CW'(k)) begin
        attr_sel = attr[k];
        w_sel    = wrom[k];
      end
    end
  end

  svm_lns_mul #(.LOGW(LOGW)) u_mul (.a_i(attr_sel), .b_i(w_sel), .p_o(prod));
  svm_lns_add #(.LOGW(LOGW), .FRAC(FRAC)) u_add (.a_i(acc_q), .b_i(prod), .y_o(acc_sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= BIAS;
    else if (step) acc_q <= acc_sum;
  end

  assign class_o = ~acc_q[LOGW];

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (acc_q == BIAS && busy)); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(inst_q)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(acc_q)); // R9
  AST_CANCEL_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && prod[LOGW] != acc_q[LOGW] && prod[LOGW-1:0] == acc_q[LOGW-1:0])
      |=> (acc_q == {1'b0, LMIN_BITS})); // R4
endmodule

// File: tb/tb_lns_svm_classifier.sv
`timescale 1ns/1ps
module tb_lns_svm_classifier;
  localparam int N = 4;
  localparam int W = 10;
  localparam logic [N*W-1:0] WTS = {10'h1F0, 10'h008, 10'h210, 10'h000};
  localparam logic [W-1:0] BIASV = 10'h3E0;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [N*W-1:0] inst_i;
  logic done_o, class_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int  m_buf [N];
  int  m_acc, m_cnt;
  bit  m_busy, m_done;
  int  last_cls;
  int  seed = 32'h1234_5678;

  lns_svm_classifier #(.N_ATTR(N), .WEIGHTS(WTS), .BIAS(BIASV)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .inst_i(inst_i),
    .done_o(done_o), .class_o(class_o)
  );

  always #5 clk = ~clk;

  function automatic int lg(int w); return ((w & 511) ^ 256) - 256; endfunction
  function automatic int sgn(int w); return (w >> 9) & 1; endfunction
  function automatic int mk(int s, int l); return s * 512 + (l & 511); endfunction
  function automatic int clampl(int l);
    if (l > 255) return 255;
    if (l < -256) return -256;
    return l;
  endfunction

  function automatic int ref_mul(int a, int b);
    return mk(sgn(a) ^ sgn(b), clampl(lg(a) + lg(b)));
  endfunction

  function automatic int ref_add(int a, int b);
    int hi, lo, big, dlt, n, f, t, d, p, l;
    if (lg(a) >= lg(b)) begin hi = a; lo = b; end else begin hi = b; lo = a; end
    big = lg(hi);
    dlt = big - lg(lo);
    n = dlt / 16 + ((dlt % 16) != 0 ? 1 : 0);
    f = ((dlt % 16) == 0) ? 0 : 16 - (dlt % 16);
    t = (n > 12) ? 0 : ((16 + f) * 256) / (2 ** n);
    if (sgn(a) == sgn(b)) return mk(sgn(a), clampl(big + t / 256));
    if (t == 0) return hi;
    d = 4096 - t;
    if (d == 0) return mk(0, -256);
    p = 0;
    while ((2 ** (p + 1)) <= d) p++;
    l = big + 16 * (p - 12) + (((d * (2 ** (11 - p))) / 128) % 16);
    return mk(sgn(hi), clampl(l));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit st, input logic [N*W-1:0] inst);
    if (m_busy) begin
      m_acc  = ref_add(m_acc, ref_mul(m_buf[m_cnt], int'(WTS[m_cnt*W +: W])));
      m_done = (m_cnt == N - 1);
      if (m_done) m_busy = 0; else m_cnt++;
    end else begin
      m_done = 0;
      if (st) begin
        for (int k = 0; k < N; k++) m_buf[k] = int'(inst[k*W +: W]);
        m_acc  = int'(BIASV);
        m_cnt  = 0;
        m_busy = 1;
      end
    end
  endtask

  task automatic tick(input bit st, input logic [N*W-1:0] inst);
    int mcls;
    start_i = st;
    inst_i  = inst;
    @(posedge clk);
    model_step(st, inst);
    @(negedge clk);
    mcls = (sgn(m_acc) == 0) ? 1 : 0;
    chk(done_o == m_done, "R6 R7 done timing", int'(done_o), int'(m_done));
    if (m_done) begin
      chk(int'(class_o) == mcls, "R1 R2 R3 R7 class at done", int'(class_o), mcls);
      last_cls = int'(class_o);
    end else if (!m_busy) begin
      chk(int'(class_o) == mcls, "R9 idle class held", int'(class_o), mcls);
    end
  endtask

  task automatic run(input logic [N*W-1:0] inst);
    tick(1'b1, inst);
    while (!m_done) tick(1'b0, '0);
  endtask

  function automatic logic [W-1:0] w(input int s, input int l);
    return W'(mk(s, l));
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    rst_n = 1'b0; start_i = 1'b0; inst_i = '0;
    m_acc = 0; m_cnt = 0; m_busy = 0; m_done = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done_o == 1'b0, "R10 done after reset", int'(done_o), 0);
    chk(class_o == 1'b1, "R10 class after reset", int'(class_o), 1);
    rst_n = 1'b1;
    tick(0, '0);

    // R5 R6 positive sum
    run({w(0,32), w(0,32), w(0,32), w(0,32)});
    chk(last_cls == 1, "R2 R3 positive instance", last_cls, 1);
    // back-to-back start in the done cycle, negative sum
    run({w(0,-128), w(0,-128), w(0,32), w(0,32)});
    chk(last_cls == 0, "R3 negative instance", last_cls, 0);

    // R4 exact cancellation then tiny positive products
    run({w(0,-256), w(0,-256), w(1,-256), w(0,-32)});
    chk(last_cls == 1, "R4 cancellation reads positive", last_cls, 1);

    // R1 saturation high, then cancellation of saturated values
    run({w(0,0), w(1,0), w(0,255), w(0,255)});
    chk(last_cls == 0, "R1 saturated products", last_cls, 0);

    // R8 start while busy ignored
    v = {w(0,32), w(0,32), w(0,32), w(0,32)};
    tick(1'b1, v);
    tick(1'b0, '0);
    tick(1'b1, {w(1,100), w(1,100), w(1,100), w(1,100)});
    while (!m_done) tick(1'b1, {w(1,100), w(1,100), w(1,100), w(1,100)});
    chk(last_cls == 1, "R8 mid-run start ignored", last_cls, 1);

    // R9 idle hold with clock running
    for (int i = 0; i < 40; i++) tick(1'b0, {w(1,5), w(1,5), w(1,5), w(1,5)});

    // pseudo-random instances
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < N; k++) begin
        seed = seed * 1103515245 + 12345;
        v[k*W +: W] = W'(seed >>> 12);
      end
      run(v);
      if (i % 3 == 0) repeat (2) tick(1'b0, '0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule